// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and date for a chip. A one-cycle pulse on `tick_i`, once per second, drives it. Time is held as packed BCD hours, minutes and seconds in 24-hour form. The calendar is held as packed BCD century, year, month, date and a weekday from 1 to 7. Leap years and month lengths are handled inside the core. Software reaches the core through a small word-addressed register port. Writes and the read data mux both sit on the core's own clock, so every read returns one registered word in full.

To change the time or date, software first unlocks the control register with a key. It then raises one or both update requests. At the next second pulse the core stops counting and sets an acknowledge flag. While counting is stopped, software writes the new words, then drops the requests, and counting resumes on the following pulse. Stored words are checked against their legal BCD ranges. An illegal word is reported through two validity flags and the counter holds still. Event flags for acknowledge, second, minute change and day change are sticky. They are cleared by writing ones, and a mask that is set and cleared through separate write ports combines them into one interrupt line.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time and calendar words read back as the parameter values `RST_TIME` and `RST_CAL`. The status, mask, control and validity registers read 0, the lock register reads 1 (locked), and `irq_o` is 0.
- R2: A write to LOCK (address 9) whose bits 31:8 equal `LOCK_KEY` loads the lock state from bit 0 (1 = locked). A write with any other key leaves the lock state unchanged. While locked, writes to CTRL (address 0) are ignored.
- R3: On a pulse of `tick_i` with no update request pending and both words legal, the seconds advance by one in BCD, and status bit 2 (second event) is set.
- R4: Seconds 59 roll over to 00 and advance the minutes, which sets status bit 3. Minutes 59 roll over into the hours. Hour 23 rolls over to 00, which advances the date and sets status bit 4. Time word layout: seconds in bits 7:0, minutes in bits 15:8, hours in bits 21:16.
- R5: The date rolls over after the last day of its month: 28 or 29 in month 02, 30 in months 04, 06, 09 and 11, and 31 otherwise. February has 29 days when the two-digit year is divisible by 4, and year 00 counts as a leap year. Month 12 rolls over to 01 and advances the year. Year 99 rolls over to 00 and advances the century, which wraps from 99 to 00. The weekday steps on every date change and wraps from 7 to 1. Calendar word layout: century in bits 7:0, year in bits 15:8, month in bits 20:16, weekday in bits 23:21, date in bits 29:24.
- R6: While CTRL bit 0 (time update) or CTRL bit 1 (calendar update) is set, ticks do not advance the time or the calendar. The first tick after a request sets status bit 0 (acknowledge). Counting resumes only once both request bits are clear.
- R7: A write to TIME (address 1) is stored only after the acknowledge, while CTRL bit 0 is set. A write to CAL (address 2) is stored only after the acknowledge, while CTRL bit 1 is set. Any other write to these registers is ignored.
- R8: VALID (address 8) bit 0 is set while the stored time holds a non-BCD digit or a field out of range. Bit 1 is set while the calendar holds a non-BCD digit, a date outside 1 to the length of its month, a month outside 1..12, or weekday 0.
- R9: While either validity bit is set, ticks leave the time and the calendar unchanged.
- R10: A one written to a bit of CLEAR (address 4) clears that status bit (STATUS, address 3). If an event sets the same bit in the same cycle, the event wins. Status bits never clear on their own.
- R11: Ones written to IEN (address 5) set mask bits, and ones written to IDIS (address 6) clear them. The mask reads at address 7. `irq_o` is high while any status bit has its mask bit set.
- R12: Between ticks and accepted writes, reads of the time and calendar words return the same value on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| tick_i | input | 1 | One-cycle pulse once per second |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational from registers) |
| irq_o | output | 1 | OR of status bits under the mask |

## Verification
The bench builds the core with the reset time set to 23:59:58 and the reset calendar set to 31 December of year 99, century 20, weekday 7. The second tick after reset therefore carries through every field at once: second, minute, hour, date, month, year, century and weekday. Later dates are loaded through the update handshake, using the default key. Directed cases cover the leap rule for years 24, 23 and 00. Random times, many placed one second before a rollover, are checked against a binary-arithmetic calendar model kept in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int STAT_W   = 6;
    localparam int ST_ACK   = 0;
    localparam int ST_ALARM = 1;
    localparam int ST_SEC   = 2;
    localparam int ST_TIMEV = 3;
    localparam int ST_CALEV = 4;
    localparam int ST_ERR   = 5;

    typedef enum logic [3:0] {
        RA_CTRL   = 4'd0,
        RA_TIME   = 4'd1,
        RA_CAL    = 4'd2,
        RA_STATUS = 4'd3,
        RA_CLEAR  = 4'd4,
        RA_IEN    = 4'd5,
        RA_IDIS   = 4'd6,
        RA_IMASK  = 4'd7,
        RA_VALID  = 4'd8,
        RA_LOCK   = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic [5:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } clk_time_t;

    typedef struct packed {
        logic [5:0] date;
        logic [2:0] wday;
        logic [4:0] month;
        logic [7:0] year;
        logic [7:0] cent;
    } clk_cal_t;

    localparam int TIME_W = $bits(clk_time_t);
    localparam int CAL_W  = $bits(clk_cal_t);

    function automatic logic bcd_in_range(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

    function automatic logic [7:0] bcd_inc(logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four: the tens digit's parity picks the unit set.
    function automatic logic leap_year(logic [7:0] yr);
        if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_len(logic [4:0] mon, logic [7:0] yr);
        case (mon)
            5'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic time_legal(clk_time_t t);
        return bcd_in_range(t.sec, 8'h00, 8'h59) &&
               bcd_in_range(t.min, 8'h00, 8'h59) &&
               bcd_in_range({2'b00, t.hour}, 8'h00, 8'h23);
    endfunction

    function automatic logic cal_legal(clk_cal_t c);
        return bcd_in_range({2'b00, c.date}, 8'h01, month_len(c.month, c.year)) &&
               bcd_in_range({3'b000, c.month}, 8'h01, 8'h12) &&
               bcd_in_range(c.year, 8'h00, 8'h99) &&
               bcd_in_range(c.cent, 8'h00, 8'h99) &&
               (c.wday != 3'd0);
    endfunction

endpackage

// File: rtl/rtc_lock.sv
module rtc_lock #(
    parameter int          DATA_W = 32,
    parameter int          KEY_W  = 24,
    parameter logic [KEY_W-1:0] KEY = 24'h525443
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              locked_o
);

    typedef struct packed {
        logic locked;
    } lock_state_t;

    lock_state_t s_q, s_d;
    logic        key_ok;

    always_comb begin
        s_d    = s_q;
        key_ok = (wdata_i[DATA_W-1 -: KEY_W] == KEY);
        if (we_i && key_ok) begin
            s_d.locked = wdata_i[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{locked: 1'b1};
        else        s_q <= s_d;
    end

    assign locked_o = s_q.locked;

    assert_badkey_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (wdata_i[DATA_W-1 -: KEY_W] != KEY)) |=> $stable(s_q.locked));

endmodule

// File: rtl/rtc_sync_ctrl.sv
module rtc_sync_ctrl #(
    parameter int REQ_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ctrl_we_i,
    input  logic [REQ_W-1:0] req_wdata_i,
    output logic [REQ_W-1:0] req_o,
    output logic             granted_o,
    output logic             ack_evt_o
);

    typedef struct packed {
        logic [REQ_W-1:0] req;
        logic             granted;
    } sync_state_t;

    sync_state_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        ack_evt_o = tick_i && (s_q.req != '0) && !s_q.granted;
        if (tick_i && (s_q.req != '0)) begin
            s_d.granted = 1'b1;
        end
        if (ctrl_we_i) begin
            s_d.req = req_wdata_i;
        end
        if (s_d.req == '0) begin
            s_d.granted = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_o     = s_q.req;
    assign granted_o = s_q.granted;

    assert_grant_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.granted) |-> $past(tick_i));

    assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.granted |-> (s_q.req != '0));

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
#(
    parameter logic [31:0] RST_TIME = 32'h0000_0000,
    parameter logic [31:0] RST_CAL  = 32'h0121_0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    input  logic              time_we_i,
    input  logic              cal_we_i,
    input  logic [TIME_W-1:0] time_wdata_i,
    input  logic [CAL_W-1:0]  cal_wdata_i,
    output clk_time_t         time_o,
    output clk_cal_t          cal_o,
    output logic              min_evt_o,
    output logic              day_evt_o
);

    typedef struct packed {
        clk_time_t t;
        clk_cal_t  c;
    } cnt_state_t;

    cnt_state_t s_q, s_d;
    logic sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap, year_wrap;
    logic [7:0] hour_nx, date_nx, month_nx;

    always_comb begin
        s_d       = s_q;
        sec_wrap  = (s_q.t.sec == 8'h59);
        min_wrap  = sec_wrap && (s_q.t.min == 8'h59);
        hour_wrap = min_wrap && (s_q.t.hour == 6'h23);
        date_wrap = hour_wrap && ({2'b00, s_q.c.date} == month_len(s_q.c.month, s_q.c.year));
        mon_wrap  = date_wrap && (s_q.c.month == 5'h12);
        year_wrap = mon_wrap && (s_q.c.year == 8'h99);
        hour_nx   = bcd_inc({2'b00, s_q.t.hour});
        date_nx   = bcd_inc({2'b00, s_q.c.date});
        month_nx  = bcd_inc({3'b000, s_q.c.month});

        if (advance_i) begin
            s_d.t.sec = sec_wrap ? 8'h00 : bcd_inc(s_q.t.sec);
            if (sec_wrap) begin
                s_d.t.min = (s_q.t.min == 8'h59) ? 8'h00 : bcd_inc(s_q.t.min);
            end
            if (min_wrap) begin
                s_d.t.hour = (s_q.t.hour == 6'h23) ? 6'h00 : hour_nx[5:0];
            end
            if (hour_wrap) begin
                s_d.c.date = date_wrap ? 6'h01 : date_nx[5:0];
                s_d.c.wday = (s_q.c.wday == 3'd7) ? 3'd1 : s_q.c.wday + 3'd1;
            end
            if (date_wrap) begin
                s_d.c.month = mon_wrap ? 5'h01 : month_nx[4:0];
            end
            if (mon_wrap) begin
                s_d.c.year = year_wrap ? 8'h00 : bcd_inc(s_q.c.year);
            end
            if (year_wrap) begin
                s_d.c.cent = (s_q.c.cent == 8'h99) ? 8'h00 : bcd_inc(s_q.c.cent);
            end
        end

        if (time_we_i) s_d.t = clk_time_t'(time_wdata_i);
        if (cal_we_i)  s_d.c = clk_cal_t'(cal_wdata_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= cnt_state_t'({RST_TIME[TIME_W-1:0], RST_CAL[CAL_W-1:0]});
        else        s_q <= s_d;
    end

    assign time_o    = s_q.t;
    assign cal_o     = s_q.c;
    assign min_evt_o = advance_i && sec_wrap;
    assign day_evt_o = advance_i && hour_wrap;

    // A legal date and time stays legal across any number of steps.
    assert_legal_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !time_we_i && !cal_we_i && time_legal(s_q.t) && cal_legal(s_q.c))
        |=> (time_legal(s_q.t) && cal_legal(s_q.c)));

    assert_weekday_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !cal_we_i && (s_q.c.wday != 3'd0)) |=> (s_q.c.wday != 3'd0));

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
    parameter int SRC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_i,
    input  logic             clr_we_i,
    input  logic             ien_we_i,
    input  logic             idis_we_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] status_o,
    output logic [SRC_W-1:0] mask_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [SRC_W-1:0] status;
        logic [SRC_W-1:0] mask;
    } irq_state_t;

    irq_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (clr_we_i)  s_d.status = s_q.status & ~wdata_i;
        s_d.status = s_d.status | set_i;
        if (ien_we_i)  s_d.mask = s_d.mask | wdata_i;
        if (idis_we_i) s_d.mask = s_d.mask & ~wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = s_q.status;
    assign mask_o   = s_q.mask;
    assign irq_o    = |(s_q.status & s_q.mask);

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((s_q.status & $past(wdata_i & ~set_i)) == '0));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((s_q.status & $past(s_q.status)) == $past(s_q.status)));

    assert_ien_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_we_i && !idis_we_i) |=> ((s_q.mask & $past(wdata_i)) == $past(wdata_i)));

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int          KEY_W    = 24,
    parameter logic [KEY_W-1:0] LOCK_KEY = 24'h525443,
    parameter logic [31:0] RST_TIME = 32'h0000_0000,
    parameter logic [31:0] RST_CAL  = 32'h0121_0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);

    localparam int DATA_W = 32;
    localparam int REQ_W  = 2;

    logic             locked, granted, ack_evt, min_evt, day_evt;
    logic [REQ_W-1:0] req;
    logic             ctrl_we, lock_we, time_we, cal_we, clr_we, ien_we, idis_we;
    logic             nv_time, nv_cal, advance;
    clk_time_t        time_w;
    clk_cal_t         cal_w;
    logic [STAT_W-1:0] stat_set, status, mask;

    always_comb begin
        ctrl_we = bus_we_i && (bus_addr_i == ADDR_W'(RA_CTRL)) && !locked;
        lock_we = bus_we_i && (bus_addr_i == ADDR_W'(RA_LOCK));
        time_we = bus_we_i && (bus_addr_i == ADDR_W'(RA_TIME)) && granted && req[0];
        cal_we  = bus_we_i && (bus_addr_i == ADDR_W'(RA_CAL))  && granted && req[1];
        clr_we  = bus_we_i && (bus_addr_i == ADDR_W'(RA_CLEAR));
        ien_we  = bus_we_i && (bus_addr_i == ADDR_W'(RA_IEN));
        idis_we = bus_we_i && (bus_addr_i == ADDR_W'(RA_IDIS));
        nv_time = !time_legal(time_w);
        nv_cal  = !cal_legal(cal_w);
        advance = tick_i && (req == '0) && !nv_time && !nv_cal;

        stat_set           = '0;
        stat_set[ST_ACK]   = ack_evt;
        stat_set[ST_SEC]   = advance;
        stat_set[ST_TIMEV] = min_evt;
        stat_set[ST_CALEV] = day_evt;
    end

    rtc_lock #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(LOCK_KEY)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (lock_we),
        .wdata_i  (bus_wdata_i),
        .locked_o (locked)
    );

    rtc_sync_ctrl #(.REQ_W(REQ_W)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .ctrl_we_i   (ctrl_we),
        .req_wdata_i (bus_wdata_i[REQ_W-1:0]),
        .req_o       (req),
        .granted_o   (granted),
        .ack_evt_o   (ack_evt)
    );

    rtc_counter #(.RST_TIME(RST_TIME), .RST_CAL(RST_CAL)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance_i    (advance),
        .time_we_i    (time_we),
        .cal_we_i     (cal_we),
        .time_wdata_i (bus_wdata_i[TIME_W-1:0]),
        .cal_wdata_i  (bus_wdata_i[CAL_W-1:0]),
        .time_o       (time_w),
        .cal_o        (cal_w),
        .min_evt_o    (min_evt),
        .day_evt_o    (day_evt)
    );

    rtc_irq #(.SRC_W(STAT_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (stat_set),
        .clr_we_i  (clr_we),
        .ien_we_i  (ien_we),
        .idis_we_i (idis_we),
        .wdata_i   (bus_wdata_i[STAT_W-1:0]),
        .status_o  (status),
        .mask_o    (mask),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(RA_CTRL):   bus_rdata_o = DATA_W'(req);
            ADDR_W'(RA_TIME):   bus_rdata_o = DATA_W'(time_w);
            ADDR_W'(RA_CAL):    bus_rdata_o = DATA_W'(cal_w);
            ADDR_W'(RA_STATUS): bus_rdata_o = DATA_W'(status);
            ADDR_W'(RA_IMASK):  bus_rdata_o = DATA_W'(mask);
            ADDR_W'(RA_VALID):  bus_rdata_o = DATA_W'({nv_cal, nv_time});
            ADDR_W'(RA_LOCK):   bus_rdata_o = DATA_W'(locked);
            default:            bus_rdata_o = '0;
        endcase
    end

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !time_we) |=> (time_w != $past(time_w)));

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((req != '0) && !time_we && !cal_we) |=> ($stable(time_w) && $stable(cal_w)));

    assert_wr_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && (bus_addr_i == ADDR_W'(RA_TIME)) && !granted && !tick_i) |=> $stable(time_w));

    assert_invalid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((nv_time || nv_cal) && !time_we && !cal_we) |=> ($stable(time_w) && $stable(cal_w)));

    assert_read_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !time_we && !cal_we) |=> ($stable(time_w) && $stable(cal_w)));

endmodule

// File: tb/test_rtc_bcd_core.sv
module test_rtc_bcd_core;

    localparam logic [31:0] T0  = 32'h0023_5958;
    localparam logic [31:0] C0  = 32'h31F2_9920;
    localparam logic [23:0] KEY = 24'h525443;
    localparam logic [3:0] A_CTRL = 4'd0, A_TIME = 4'd1, A_CAL = 4'd2, A_STAT = 4'd3,
                           A_CLR = 4'd4, A_IEN = 4'd5, A_IDIS = 4'd6, A_MASK = 4'd7,
                           A_VALID = 4'd8, A_LOCK = 4'd9;

    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #5 clk = ~clk;

    rtc_bcd_core #(.ADDR_W(4), .KEY_W(24), .LOCK_KEY(KEY), .RST_TIME(T0), .RST_CAL(C0)) i_rtc_bcd_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    int n_chk = 0, n_fail = 0;
    int m_sec, m_min, m_hr, m_date, m_mon, m_yr, m_cent, m_wd;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] pack_time(int h, int m, int s);
        logic [7:0] hb;
        hb = bcd(h);
        return {10'b0, hb[5:0], bcd(m), bcd(s)};
    endfunction

    function automatic logic [31:0] pack_cal(int d, int wd, int mo, int y, int c);
        logic [7:0] db, mb;
        db = bcd(d);
        mb = bcd(mo);
        return {2'b0, db[5:0], 3'(wd), mb[4:0], bcd(y), bcd(c)};
    endfunction

    function automatic logic [31:0] m_time();
        return pack_time(m_hr, m_min, m_sec);
    endfunction

    function automatic logic [31:0] m_cal();
        return pack_cal(m_date, m_wd, m_mon, m_yr, m_cent);
    endfunction

    task automatic step();
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hr++; end
        if (m_hr == 24) begin
            m_hr = 0;
            m_wd = (m_wd == 7) ? 1 : m_wd + 1;
            m_date++;
            if (m_date > dim(m_mon, m_yr)) begin m_date = 1; m_mon++; end
            if (m_mon == 13) begin m_mon = 1; m_yr++; end
            if (m_yr == 100) begin m_yr = 0; m_cent = (m_cent + 1) % 100; end
        end
    endtask

    task automatic set_model(int h, int mi, int s, int d, int mo, int y, int c, int wd);
        m_hr = h; m_min = mi; m_sec = s; m_date = d; m_mon = mo; m_yr = y; m_cent = c; m_wd = wd;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic program_model();
        wr(A_CTRL, 32'd3);
        pulse();
        wr(A_TIME, m_time());
        wr(A_CAL, m_cal());
        wr(A_CTRL, 32'd0);
    endtask

    task automatic tick_and_check(string req);
        logic [31:0] v;
        pulse();
        step();
        rd(A_TIME, v); chk({req, " time"}, v, m_time());
        rd(A_CAL, v);  chk({req, " calendar"}, v, m_cal());
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int seed_init;
        seed_init = $urandom(20240);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_TIME, v);  chk("R1 time", v, T0);
        rd(A_CAL, v);   chk("R1 calendar", v, C0);
        rd(A_STAT, v);  chk("R1 status", v, 32'h0);
        rd(A_MASK, v);  chk("R1 mask", v, 32'h0);
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        rd(A_VALID, v); chk("R1 valid", v, 32'h0);
        rd(A_LOCK, v);  chk("R1 lock", v, 32'h1);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3 single step, then R4/R5 full rollover chain
        set_model(23, 59, 58, 31, 12, 99, 20, 7);
        tick_and_check("R3");
        rd(A_STAT, v); chk("R3 second event", v, 32'h04);
        tick_and_check("R5 year-century rollover");
        rd(A_STAT, v); chk("R4 minute and day events", v, 32'h1C);

        // R10 clear and set-wins
        wr(A_CLR, 32'h1C);
        rd(A_STAT, v); chk("R10 clear", v, 32'h0);
        @(negedge clk);
        we = 1'b1; addr = A_CLR; wdata = 32'h04; tick = 1'b1;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
        step();
        rd(A_STAT, v); chk("R10 set wins over clear", v, 32'h04);
        rd(A_TIME, v); chk("R3 time", v, m_time());

        // R11 mask
        wr(A_IEN, 32'h04);
        rd(A_MASK, v); chk("R11 mask set", v, 32'h04);
        chk("R11 irq high", {31'b0, irq}, 32'h1);
        wr(A_IDIS, 32'h04);
        rd(A_MASK, v); chk("R11 mask cleared", v, 32'h0);
        chk("R11 irq low", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h3F);
        wr(A_CLR, 32'h3F);
        chk("R11 irq low after clear", {31'b0, irq}, 32'h0);
        wr(A_IDIS, 32'h3F);

        // R2 lock
        wr(A_CTRL, 32'd3);
        rd(A_CTRL, v); chk("R2 ctrl ignored while locked", v, 32'h0);
        wr(A_LOCK, {KEY ^ 24'h000001, 8'h00});
        rd(A_LOCK, v); chk("R2 bad key ignored", v, 32'h1);
        wr(A_LOCK, {KEY, 8'h00});
        rd(A_LOCK, v); chk("R2 unlock", v, 32'h0);
        tick_and_check("R3 running");

        // R6 request and acknowledge
        wr(A_CTRL, 32'd3);
        rd(A_CTRL, v); chk("R6 ctrl", v, 32'h3);
        pulse();
        rd(A_STAT, v); chk("R6 ack", v & 32'h1, 32'h1);
        rd(A_TIME, v); chk("R6 frozen at ack", v, m_time());
        pulse();
        rd(A_TIME, v); chk("R6 still frozen", v, m_time());

        // R7 accepted writes, R5 leap day
        set_model(23, 59, 59, 28, 2, 24, 20, 3);
        wr(A_TIME, m_time());
        wr(A_CAL, m_cal());
        rd(A_TIME, v); chk("R7 time write", v, m_time());
        rd(A_CAL, v);  chk("R7 cal write", v, m_cal());
        wr(A_CTRL, 32'd0);
        tick_and_check("R5 leap Feb 29");
        set_model(23, 59, 59, 29, 2, 24, 20, 4);
        program_model();
        tick_and_check("R5 leap to March");

        // R7 ignored writes
        rd(A_TIME, v2);
        wr(A_TIME, pack_time(12, 34, 56));
        rd(A_TIME, v); chk("R7 time write without request", v, v2);
        wr(A_CTRL, 32'd1);
        pulse();
        rd(A_CAL, v2);
        wr(A_CAL, pack_cal(5, 2, 6, 30, 20));
        rd(A_CAL, v); chk("R7 cal write without cal request", v, v2);
        wr(A_TIME, pack_time(10, 0, 0));
        rd(A_TIME, v); chk("R7 time-only request", v, pack_time(10, 0, 0));

        // R8 / R9 validity
        wr(A_TIME, 32'h0000_0060);
        rd(A_VALID, v); chk("R8 illegal seconds", v, 32'h1);
        wr(A_CTRL, 32'd0);
        pulse();
        rd(A_TIME, v); chk("R9 hold while invalid", v, 32'h0000_0060);
        wr(A_CTRL, 32'd3);
        pulse();
        wr(A_TIME, pack_time(1, 2, 3));
        wr(A_CAL, pack_cal(30, 1, 2, 25, 20));
        rd(A_VALID, v); chk("R8 Feb 30 illegal", v, 32'h2);
        wr(A_CTRL, 32'd0);
        pulse();
        rd(A_CAL, v); chk("R9 calendar held", v, pack_cal(30, 1, 2, 25, 20));
        rd(A_TIME, v); chk("R9 time held", v, pack_time(1, 2, 3));

        // R5 non-leap and year 00
        set_model(23, 59, 59, 28, 2, 23, 20, 7);
        program_model();
        tick_and_check("R5 non-leap to March");
        set_model(23, 59, 59, 28, 2, 0, 21, 2);
        program_model();
        tick_and_check("R5 year 00 leap");

        // R12 steady reads
        rd(A_TIME, v2);
        repeat (5) @(negedge clk);
        rd(A_TIME, v); chk("R12 steady time", v, v2);

        // Random rollovers
        for (int i = 0; i < 40; i++) begin
            int k;
            m_sec  = ($urandom % 2) ? 59 : $urandom % 60;
            m_min  = ($urandom % 2) ? 59 : $urandom % 60;
            m_hr   = ($urandom % 2) ? 23 : $urandom % 24;
            m_mon  = 1 + $urandom % 12;
            m_yr   = ($urandom % 4) == 0 ? 99 : $urandom % 100;
            m_cent = $urandom % 100;
            m_wd   = 1 + $urandom % 7;
            m_date = ($urandom % 2) ? dim(m_mon, m_yr) : 1 + $urandom % dim(m_mon, m_yr);
            if ($urandom % 3 == 0) m_mon = 12;
            if (m_date > dim(m_mon, m_yr)) m_date = dim(m_mon, m_yr);
            program_model();
            k = 1 + $urandom % 3;
            for (int j = 0; j < k; j++) begin
                tick_and_check("R4 R5 random");
            end
        end

        wr(A_LOCK, {KEY, 8'h01});
        rd(A_LOCK, v); chk("R2 relock", v, 32'h1);

        summary();
        $finish;
    end

endmodule